// File: doc/BRIEF.md
# Power Management Wake Signal Controller

This block drives the power-management sideband pins of a network controller from internal status. It turns a received wake event into a latched, active-low power-management request. It stretches a magic-packet indication into a wake pulse whose length is timed in clock cycles. It reports the PHY power need for the current device power state as a two-bit code, and each bit of that code can have its polarity flipped. It also gives a global reset that follows the board's power-good input.

The power-good input acts at once on the outputs. While it is low, every output shows its idle value and every internal register is cleared at the next clock edge. After power-good rises, the global reset is held for a parameterised number of edges. The auxiliary-power input is registered and shown as a status bit. That bit tells the wake logic it may stay alive in the D3cold state.

Top module: `pm_wake_ctrl`

## Requirements
- R1: While `pwr_good_i` is 0, in the same cycle, `pme_n_o` is 1, `apm_wake_o` is 0, `glob_rst_o` is 1 and `aux_ok_o` is 0. `pwr_state_o` shows code 00 after polarity is applied, so it equals {`inv_full_i`, `inv_link_i`}.
- R2: After `pwr_good_i` rises, `glob_rst_o` stays 1 through the first RST_HOLD rising clock edges and falls after the RST_HOLD-th edge.
- R3: A `wake_evt_i` strobe sampled while `pme_en_i` or `apme_en_i` is 1 drives `pme_n_o` to 0 from the next cycle. With both enables at 0 the strobe leaves `pme_n_o` at 1.
- R4: Once asserted, `pme_n_o` stays 0 until a cycle samples `pme_clr_i` or `pme_w1c_i` at 1, and it returns to 1 in the next cycle. A qualifying wake event in the same cycle as a clear wins, and the request stays asserted.
- R5: A `magic_pkt_i` strobe sampled while `apm_wake_en_i` is 1 makes `apm_wake_o` high for exactly PULSE_CYCLES cycles, starting the next cycle. PULSE_CYCLES = CLK_HZ/1e6 × PULSE_US. With `apm_wake_en_i` at 0 the strobe has no effect.
- R6: A qualifying magic packet that arrives while the pulse is high restarts the count, so the pulse ends PULSE_CYCLES cycles after the latest such packet.
- R7: `dstate_i` uses the codes 0 = D0 uninitialised, 1 = D0 active, 2 = D1, 3 = D3. One cycle after a state is sampled, the uninverted code is 11 in D0 active. In the other states it is 01 when `pme_en_i` or `apme_en_i` is 1 and 00 otherwise. Bit 1 means full power is needed and bit 0 means the link is needed.
- R8: `pwr_state_o[1]` is the full-power bit XOR `inv_full_i`, and `pwr_state_o[0]` is the link bit XOR `inv_link_i`. The inversion follows the invert inputs in the same cycle.
- R9: The uninverted power-state code is never 10.
- R10: `aux_ok_o` equals `aux_pwr_i` as sampled at the previous clock edge, outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good_i | input | 1 | Power good; 0 holds the block in reset |
| aux_pwr_i | input | 1 | Auxiliary power present |
| wake_evt_i | input | 1 | Wake event strobe |
| magic_pkt_i | input | 1 | Magic packet received strobe |
| pme_en_i | input | 1 | PME enable |
| apme_en_i | input | 1 | Advanced power management enable |
| apm_wake_en_i | input | 1 | Magic-packet wake pulse enable |
| inv_full_i | input | 1 | Invert full-power bit of the power-state code |
| inv_link_i | input | 1 | Invert link bit of the power-state code |
| dstate_i | input | 2 | Current device power state |
| pme_clr_i | input | 1 | Software clear strobe for the PME request |
| pme_w1c_i | input | 1 | PME status write-one-to-clear strobe |
| pme_n_o | output | 1 | Active-low PME request (open-drain style) |
| apm_wake_o | output | 1 | Timed magic-packet wake pulse |
| pwr_state_o | output | 2 | Power-state code after polarity |
| glob_rst_o | output | 1 | Global reset |
| aux_ok_o | output | 1 | Auxiliary power status for D3cold wake |

## Verification
A wrong PME latch state shows on `pme_n_o` one cycle after the strobe or clear that caused it, and it then stays wrong until the next clear. This makes a lost or sticky request visible within a few cycles. A wrong pulse counter shows up only at the pulse's trailing edge, PULSE_CYCLES cycles after the trigger. For that reason every pulse and restart is followed to the cycle where it ends, and one cycle past it. Errors in the reset-hold counter or in the power-state register show within one cycle of a power-good edge or a state change.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

    typedef enum logic [1:0] {
        DS_D0_UNINIT = 2'd0,
        DS_D0_ACTIVE = 2'd1,
        DS_D1        = 2'd2,
        DS_D3        = 2'd3
    } dstate_e;

    typedef struct packed {
        logic full;
        logic link;
    } pstate_t;

    localparam pstate_t PSTATE_IDLE = '{full: 1'b0, link: 1'b0};

    function automatic pstate_t encode_pstate(input dstate_e ds, input logic armed);
        pstate_t p;
        if (ds == DS_D0_ACTIVE) begin
            p.full = 1'b1;
            p.link = 1'b1;
        end else begin
            p.full = 1'b0;
            p.link = armed;
        end
        return p;
    endfunction

    function automatic logic [1:0] apply_polarity(input pstate_t p,
                                                  input logic inv_full,
                                                  input logic inv_link);
        return {p.full ^ inv_full, p.link ^ inv_link};
    endfunction

endpackage

// File: rtl/pm_rst_hold.sv
module pm_rst_hold #(
    parameter int RST_HOLD = 4
) (
    input  logic clk,
    input  logic pwr_good_i,
    output logic rst_o
);
    localparam int RW = (RST_HOLD < 1) ? 1 : $clog2(RST_HOLD + 1);
    localparam logic [RW-1:0] HOLD_V = RW'(RST_HOLD);

    logic [RW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (!pwr_good_i) begin
            hold_cnt <= '0;
        end else if (hold_cnt != HOLD_V) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign rst_o = !pwr_good_i || (hold_cnt != HOLD_V);
endmodule

// File: rtl/pm_pme_latch.sv
module pm_pme_latch (
    input  logic clk,
    input  logic rst,
    input  logic wake_evt_i,
    input  logic pme_en_i,
    input  logic apme_en_i,
    input  logic pme_clr_i,
    input  logic pme_w1c_i,
    output logic pme_req_o
);
    logic qualify;
    logic clear;

    assign qualify = wake_evt_i && (pme_en_i || apme_en_i);
    assign clear   = pme_clr_i || pme_w1c_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pme_req_o <= 1'b0;
        end else if (qualify) begin
            pme_req_o <= 1'b1;
        end else if (clear) begin
            pme_req_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pm_apm_pulse.sv
module pm_apm_pulse #(
    parameter int PULSE_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(PULSE_CYCLES);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (trig_i) begin
            remain <= LOAD_V;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign pulse_o = (remain != '0);
endmodule

// File: rtl/pm_state_enc.sv
module pm_state_enc
    import pm_wake_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  dstate_e dstate_i,
    input  logic    armed_i,
    input  logic    aux_pwr_i,
    output pstate_t pstate_o,
    output logic    aux_q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pstate_o <= PSTATE_IDLE;
            aux_q_o  <= 1'b0;
        end else begin
            pstate_o <= encode_pstate(dstate_i, armed_i);
            aux_q_o  <= aux_pwr_i;
        end
    end
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
    import pm_wake_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int PULSE_US = 50_000,
    parameter int RST_HOLD = 4
) (
    input  logic       clk,
    input  logic       pwr_good_i,
    input  logic       aux_pwr_i,
    input  logic       wake_evt_i,
    input  logic       magic_pkt_i,
    input  logic       pme_en_i,
    input  logic       apme_en_i,
    input  logic       apm_wake_en_i,
    input  logic       inv_full_i,
    input  logic       inv_link_i,
    input  logic [1:0] dstate_i,
    input  logic       pme_clr_i,
    input  logic       pme_w1c_i,
    output logic       pme_n_o,
    output logic       apm_wake_o,
    output logic [1:0] pwr_state_o,
    output logic       glob_rst_o,
    output logic       aux_ok_o
);
    localparam int PULSE_CYCLES = (CLK_HZ / 1_000_000) * PULSE_US;

    logic    rst;
    logic    pme_req;
    logic    pulse;
    logic    aux_q;
    pstate_t pstate_q;
    pstate_t pstate_shown;

    pm_rst_hold #(.RST_HOLD(RST_HOLD)) u_rst (
        .clk        (clk),
        .pwr_good_i (pwr_good_i),
        .rst_o      (rst)
    );

    pm_pme_latch u_pme (
        .clk        (clk),
        .rst        (rst),
        .wake_evt_i (wake_evt_i),
        .pme_en_i   (pme_en_i),
        .apme_en_i  (apme_en_i),
        .pme_clr_i  (pme_clr_i),
        .pme_w1c_i  (pme_w1c_i),
        .pme_req_o  (pme_req)
    );

    pm_apm_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (magic_pkt_i && apm_wake_en_i),
        .pulse_o (pulse)
    );

    pm_state_enc u_enc (
        .clk       (clk),
        .rst       (rst),
        .dstate_i  (dstate_e'(dstate_i)),
        .armed_i   (pme_en_i || apme_en_i),
        .aux_pwr_i (aux_pwr_i),
        .pstate_o  (pstate_q),
        .aux_q_o   (aux_q)
    );

    assign pstate_shown = rst ? PSTATE_IDLE : pstate_q;

    assign glob_rst_o  = rst;
    assign pme_n_o     = !(pme_req && !rst);
    assign apm_wake_o  = pulse && !rst;
    assign aux_ok_o    = aux_q && !rst;
    assign pwr_state_o = apply_polarity(pstate_shown, inv_full_i, inv_link_i);
endmodule

// File: rtl/pm_wake_ctrl_chk.sv
module pm_wake_ctrl_chk #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int PULSE_US = 50_000
) (
    input logic       clk,
    input logic       pwr_good_i,
    input logic       aux_pwr_i,
    input logic       wake_evt_i,
    input logic       magic_pkt_i,
    input logic       pme_en_i,
    input logic       apme_en_i,
    input logic       apm_wake_en_i,
    input logic       inv_full_i,
    input logic       inv_link_i,
    input logic [1:0] dstate_i,
    input logic       pme_clr_i,
    input logic       pme_w1c_i,
    input logic       pme_n_o,
    input logic       apm_wake_o,
    input logic [1:0] pwr_state_o,
    input logic       glob_rst_o,
    input logic       aux_ok_o
);
    localparam int PC = (CLK_HZ / 1_000_000) * PULSE_US;
    localparam int RW = $clog2(PC + 2);

    logic [RW-1:0] high_run;
    logic          restart;
    logic [1:0]    raw_code;

    assign restart  = magic_pkt_i && apm_wake_en_i;
    assign raw_code = pwr_state_o ^ {inv_full_i, inv_link_i};

    always_ff @(posedge clk) begin
        if (glob_rst_o) begin
            high_run <= '0;
        end else if (restart) begin
            high_run <= RW'(1);
        end else if (apm_wake_o) begin
            high_run <= high_run + 1'b1;
        end else begin
            high_run <= '0;
        end
    end

    assert_rst_idle_R1: assert property (@(posedge clk)
        !pwr_good_i |-> (pme_n_o && !apm_wake_o && glob_rst_o && !aux_ok_o));

    assert_pme_set_R3: assert property (@(posedge clk) disable iff (glob_rst_o)
        (wake_evt_i && (pme_en_i || apme_en_i)) |=> !pme_n_o);

    assert_pme_hold_R4: assert property (@(posedge clk) disable iff (glob_rst_o)
        (!pme_n_o && !pme_clr_i && !pme_w1c_i) |=> !pme_n_o);

    assert_pme_quiet_R3: assert property (@(posedge clk) disable iff (glob_rst_o)
        (pme_n_o && !wake_evt_i) |=> pme_n_o);

    assert_pulse_start_R5: assert property (@(posedge clk) disable iff (glob_rst_o)
        restart |=> apm_wake_o);

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (glob_rst_o)
        apm_wake_o |-> (high_run <= RW'(PC)));

    assert_pulse_idle_R5: assert property (@(posedge clk) disable iff (glob_rst_o)
        (!apm_wake_o && !restart) |=> !apm_wake_o);

    assert_no_code10_R9: assert property (@(posedge clk) disable iff (glob_rst_o)
        raw_code != 2'b10);

    assert_d0_full_R7: assert property (@(posedge clk) disable iff (glob_rst_o)
        (dstate_i == 2'd1) |=> (raw_code == 2'b11));

    assert_aux_follow_R10: assert property (@(posedge clk) disable iff (glob_rst_o)
        1'b1 |=> (aux_ok_o == $past(aux_pwr_i)));
endmodule

bind pm_wake_ctrl pm_wake_ctrl_chk #(
    .CLK_HZ   (CLK_HZ),
    .PULSE_US (PULSE_US)
) u_chk (
    .clk           (clk),
    .pwr_good_i    (pwr_good_i),
    .aux_pwr_i     (aux_pwr_i),
    .wake_evt_i    (wake_evt_i),
    .magic_pkt_i   (magic_pkt_i),
    .pme_en_i      (pme_en_i),
    .apme_en_i     (apme_en_i),
    .apm_wake_en_i (apm_wake_en_i),
    .inv_full_i    (inv_full_i),
    .inv_link_i    (inv_link_i),
    .dstate_i      (dstate_i),
    .pme_clr_i     (pme_clr_i),
    .pme_w1c_i     (pme_w1c_i),
    .pme_n_o       (pme_n_o),
    .apm_wake_o    (apm_wake_o),
    .pwr_state_o   (pwr_state_o),
    .glob_rst_o    (glob_rst_o),
    .aux_ok_o      (aux_ok_o)
);

// File: tb/pm_wake_ctrl_bench.sv
module pm_wake_ctrl_bench;
    localparam int CLK_HZ   = 50_000_000;
    localparam int PULSE_US = 1;
    localparam int HOLD     = 4;
    localparam int PC       = (CLK_HZ / 1_000_000) * PULSE_US;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       pg = 1'b0, aux = 1'b0, wake = 1'b0, magic = 1'b0;
    logic       pme_en = 1'b0, apme_en = 1'b0, apm_en = 1'b0;
    logic       invf = 1'b0, invl = 1'b0, clr = 1'b0, w1c = 1'b0;
    logic [1:0] ds = 2'd0;
    logic       pme_n, apm, grst, auxok;
    logic [1:0] ps;

    pm_wake_ctrl #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US), .RST_HOLD(HOLD)) u_pm_wake_ctrl (
        .clk(clk), .pwr_good_i(pg), .aux_pwr_i(aux), .wake_evt_i(wake),
        .magic_pkt_i(magic), .pme_en_i(pme_en), .apme_en_i(apme_en),
        .apm_wake_en_i(apm_en), .inv_full_i(invf), .inv_link_i(invl),
        .dstate_i(ds), .pme_clr_i(clr), .pme_w1c_i(w1c),
        .pme_n_o(pme_n), .apm_wake_o(apm), .pwr_state_o(ps),
        .glob_rst_o(grst), .aux_ok_o(auxok)
    );

    typedef struct {
        string      req;
        logic       pme_n;
        logic       apm;
        logic [1:0] ps;
        logic       rst;
        logic       aux;
    } item_t;

    item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Requirement model
    int         m_rcnt = 0;
    bit         m_pme  = 0;
    int         m_pc   = 0;
    logic [1:0] m_raw  = 2'b00;
    bit         m_aux  = 0;

    task automatic step(input string req);
        item_t it;
        bit rb, ra;
        @(posedge clk);
        rb = !pg || (m_rcnt < HOLD);
        if (!pg) m_rcnt = 0;
        else if (m_rcnt < HOLD) m_rcnt++;
        if (rb) begin
            m_pme = 0; m_pc = 0; m_raw = 2'b00; m_aux = 0;
        end else begin
            if (wake && (pme_en || apme_en)) m_pme = 1;
            else if (clr || w1c) m_pme = 0;
            if (magic && apm_en) m_pc = PC;
            else if (m_pc > 0) m_pc--;
            if (ds == 2'd1) m_raw = 2'b11;
            else m_raw = (pme_en || apme_en) ? 2'b01 : 2'b00;
            m_aux = aux;
        end
        ra = !pg || (m_rcnt < HOLD);
        it.req   = req;
        it.rst   = ra;
        it.pme_n = !(m_pme && !ra);
        it.apm   = (m_pc > 0) && !ra;
        it.aux   = m_aux && !ra;
        it.ps    = (ra ? 2'b00 : m_raw) ^ {invf, invl};
        exp_q.push_back(it);
        @(negedge clk);
        #2;
    endtask

    task automatic steps(input int n, input string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (pme_n !== e.pme_n || apm !== e.apm || ps !== e.ps ||
                    grst !== e.rst || auxok !== e.aux) begin
                    n_fail++;
                    $display("FAIL %s: actual pme_n=%b apm=%b ps=%b rst=%b aux=%b expected pme_n=%b apm=%b ps=%b rst=%b aux=%b",
                             e.req, pme_n, apm, ps, grst, auxok,
                             e.pme_n, e.apm, e.ps, e.rst, e.aux);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); #2;
        // R1: reset state, with inversion shown on idle code
        aux = 1; pme_en = 1; wake = 1; magic = 1; apm_en = 1;
        steps(2, "R1");
        invf = 1; step("R1");
        invl = 1; invf = 0; step("R1");
        wake = 0; magic = 0; apm_en = 0; pme_en = 0; invl = 0;
        // R2: reset hold after power good
        pg = 1;
        steps(HOLD + 2, "R2");
        // R3: wake without enables ignored
        wake = 1; step("R3");
        wake = 0; steps(2, "R3");
        // R3: wake with PME enable
        pme_en = 1; wake = 1; step("R3");
        wake = 0; pme_en = 0; steps(3, "R4");
        // R4: software clear
        clr = 1; step("R4");
        clr = 0; steps(2, "R4");
        // R3: advanced enable only
        apme_en = 1; wake = 1; step("R3");
        wake = 0; steps(2, "R4");
        // R4: write-one-to-clear
        w1c = 1; step("R4");
        w1c = 0; step("R4");
        // R4: set wins over clear
        wake = 1; clr = 1; step("R4");
        wake = 0; clr = 0; steps(2, "R4");
        clr = 1; step("R4");
        clr = 0; apme_en = 0;
        // R7 / R9: power-state codes
        ds = 2'd1; steps(2, "R7");
        ds = 2'd2; steps(2, "R7");
        pme_en = 1; ds = 2'd3; steps(2, "R9");
        pme_en = 0; ds = 2'd0; step("R7");
        apme_en = 1; step("R7");
        // R8: inversion per bit, D0 active and armed states
        ds = 2'd1; step("R8");
        invf = 1; step("R8");
        invl = 1; step("R8");
        invf = 0; step("R8");
        ds = 2'd3; steps(2, "R8");
        invl = 0; apme_en = 0; ds = 2'd0;
        // R5: magic packet ignored when disabled
        magic = 1; step("R5");
        magic = 0; steps(3, "R5");
        // R5: full pulse
        apm_en = 1; magic = 1; step("R5");
        magic = 0; steps(PC + 3, "R5");
        // R6: restart during pulse
        magic = 1; step("R6");
        magic = 0; steps(20, "R6");
        magic = 1; step("R6");
        magic = 0; steps(PC + 3, "R6");
        apm_en = 0;
        // R10: aux power status
        aux = 0; steps(2, "R10");
        aux = 1; steps(2, "R10");
        // R1: power loss mid pulse with PME latched
        pme_en = 1; wake = 1; apm_en = 1; magic = 1; step("R1");
        wake = 0; magic = 0; steps(3, "R1");
        pg = 0; invf = 1; steps(3, "R1");
        pg = 1; invf = 0; pme_en = 0; apm_en = 0;
        steps(HOLD + 3, "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule